// File: doc/BRIEF.md
# General-Purpose I/O Port with Single-Pin Event Interrupt

This block is a 16-bit general-purpose I/O controller that sits on a simple word-wide register bus. Software sets each pin's direction and its driven level, and reads back pin levels through a two-flop synchronizer followed by a sampling register. A per-pin function select tells the pad ring whether a pin follows the GPIO path or its alternate function. A control bit acts as a clock enable. While it is low, the sampled inputs and the edge detector stay frozen.

One pin at a time can raise an event. A packed mode register holds three fields: an enable, a pin number and an edge polarity. A matching edge on that pin sets a sticky GPIO status bit. That bit shares a status register with a keypad request input, and a mask register sits beside them. The interrupt output is the OR of the unmasked status bits. Reading the status register returns the GPIO bit and clears it in the same access. Software must therefore check the GPIO source first in a read.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset the direction register reads 0xFFFF (all pins inputs), every other register reads 0, and irq_o, pin_o, pin_oe_o and gpio_sel_o are 0.
- R2: The direction register (offset 1) has one bit per pin. 1 means input and 0 means output, so pin_oe_o equals its bitwise inverse, and the register reads back as written.
- R3: The output register (offset 0) drives pin_o and reads back as written.
- R4: With control bit 5 (offset 3) set, the input register (offset 2) returns pin_i three clock edges after a change. Only bit 5 of the control register is stored. Its other bits read as 0.
- R5: With control bit 5 clear, the input register holds its last value and no event is detected.
- R6: Event mode register (offset 4): bit 0 enables, bits 4:1 pick the pin, bit 5 picks the edge (1 rising, 0 falling). A matching edge on the picked pin sets status bit 1 (offset 5). An edge of the other polarity does not.
- R7: Edges on pins other than the picked one, or any edge while the enable bit is 0, leave status bit 1 clear.
- R8: A read of the status register returns status bit 1 and then clears it. Status bit 0 follows kpd_irq_i as a level and is not cleared by a read.
- R9: Mask register (offset 6): bit 0 masks the keypad source and bit 1 masks the GPIO source. irq_o is the OR of the status bits whose mask bit is 0.
- R10: The function select register (offset 7) resets to 0, drives gpio_sel_o, and reads back as written.
- R11: Reads of offsets 8 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 4 | Register word offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the access cycle |
| pin_i | input | 16 | Pad input levels |
| pin_o | output | 16 | Pad output levels |
| pin_oe_o | output | 16 | Pad output enables, 1 drives |
| gpio_sel_o | output | 16 | Per-pin GPIO/alternate function select |
| kpd_irq_i | input | 1 | Keypad interrupt request level |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an edge arriving on exactly the selected pin with the matching polarity. This requires an isolation step: a decoy edge on a neighbouring pin first, then the real edge, then the opposite edge. The bench sweeps all sixteen pins against both polarities. For each combination it first parks every pin at the inactive level, clears stale status with a read, and waits out the synchronizer latency before each status read. A separate sequence drops the clock-enable bit, moves the pins and checks that the input register and the status stay frozen.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_OUT  = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_IN   = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_MASK = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_FSEL = 4'd7;
  localparam int CTRL_CKEN_BIT = 5;
  localparam int STAT_KPD_BIT  = 0;
  localparam int STAT_GPIO_BIT = 1;
  localparam int NUM_SRC       = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det #(
  parameter int W  = 16,
  localparam int PW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [W-1:0]  sync_i,
  input  logic          mode_en_i,
  input  logic [PW-1:0] pin_sel_i,
  input  logic          rise_i,
  output logic [W-1:0]  in_o,
  output logic          evt_o
);
  logic [W-1:0] in_q, prev_q;

  // sample and history advance together, frozen while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      prev_q <= '0;
    end else if (en_i) begin
      in_q   <= sync_i;
      prev_q <= in_q;
    end
  end

  logic cur_b, old_b;
  assign cur_b = in_q[pin_sel_i];
  assign old_b = prev_q[pin_sel_i];
  assign evt_o = en_i && mode_en_i && (cur_b != old_b) && (cur_b == rise_i);
  assign in_o  = in_q;

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(in_q)); // R5
endmodule

// File: rtl/gpio_irq_ctl.sv
module gpio_irq_ctl
  import gpio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_i,
  input  logic               rd_clr_i,
  input  logic               kpd_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic               irq_o
);
  logic gpio_q;

  // a new event wins over a same-cycle read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gpio_q <= 1'b0;
    else if (evt_i)    gpio_q <= 1'b1;
    else if (rd_clr_i) gpio_q <= 1'b0;
  end

  always_comb begin
    stat_o = '0;
    stat_o[STAT_KPD_BIT]  = kpd_i;
    stat_o[STAT_GPIO_BIT] = gpio_q;
  end

  assign irq_o = |(stat_o & ~mask_i);

  AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !evt_i) |=> !gpio_q); // R8
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_q && !rd_clr_i) |=> gpio_q); // R8
  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_o); // R9
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
  import gpio_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     pin_i,
  output logic [DW-1:0]     pin_o,
  output logic [DW-1:0]     pin_oe_o,
  output logic [DW-1:0]     gpio_sel_o,
  input  logic              kpd_irq_i,
  output logic              irq_o
);
  localparam int PW       = $clog2(DW);
  localparam int EDGE_BIT = PW + 1;
  localparam int MODE_W   = PW + 2;

  logic [DW-1:0]      out_q, dir_q, fsel_q, sync_w, in_w;
  logic               cken_q, evt_w, rd_clr_w;
  logic [MODE_W-1:0]  mode_q;
  logic [NUM_SRC-1:0] mask_q, stat_w;
  logic               wr_w;

  assign wr_w     = sel_i && we_i;
  assign rd_clr_w = sel_i && !we_i && (addr_i == OFS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '1;
      fsel_q <= '0;
      cken_q <= 1'b0;
      mode_q <= '0;
      mask_q <= '0;
    end else if (wr_w) begin
      case (addr_i)
        OFS_OUT:  out_q  <= wdata_i;
        OFS_DIR:  dir_q  <= wdata_i;
        OFS_CTRL: cken_q <= wdata_i[CTRL_CKEN_BIT];
        OFS_EVT:  mode_q <= wdata_i[MODE_W-1:0];
        OFS_MASK: mask_q <= wdata_i[NUM_SRC-1:0];
        OFS_FSEL: fsel_q <= wdata_i;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(DW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  gpio_evt_det #(.W(DW)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cken_q),
    .sync_i   (sync_w),
    .mode_en_i(mode_q[0]),
    .pin_sel_i(mode_q[PW:1]),
    .rise_i   (mode_q[EDGE_BIT]),
    .in_o     (in_w),
    .evt_o    (evt_w)
  );

  gpio_irq_ctl u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_w),
    .rd_clr_i(rd_clr_w),
    .kpd_i   (kpd_irq_i),
    .mask_i  (mask_q),
    .stat_o  (stat_w),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_OUT:  rdata_o = out_q;
      OFS_DIR:  rdata_o = dir_q;
      OFS_IN:   rdata_o = in_w;
      OFS_CTRL: rdata_o[CTRL_CKEN_BIT] = cken_q;
      OFS_EVT:  rdata_o[MODE_W-1:0] = mode_q;
      OFS_STAT: rdata_o[NUM_SRC-1:0] = stat_w;
      OFS_MASK: rdata_o[NUM_SRC-1:0] = mask_q;
      OFS_FSEL: rdata_o = fsel_q;
      default:  rdata_o = '0;
    endcase
  end

  assign pin_o      = out_q;
  assign pin_oe_o   = ~dir_q;
  assign gpio_sel_o = fsel_q;

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_w && addr_i == OFS_DIR) |=> (pin_oe_o == ~$past(wdata_i))); // R2
  AST_EVT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_w[STAT_GPIO_BIT]) |-> $past(cken_q && mode_q[0])); // R6
endmodule

// File: tb/gpio_evt_port_bench.sv
`timescale 1ns/1ps
module gpio_evt_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, pins = '0, pin_o, pin_oe, gsel;
  logic        kpd = 1'b0, irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  gpio_evt_port u_gpio_evt_port (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .gpio_sel_o(gsel), .kpd_irq_i(kpd), .irq_o(irq)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(logic [15:0] v);
    @(negedge clk); pins = v;
  endtask

  logic [15:0] r;
  logic [15:0] pats [4] = '{16'h0000, 16'hA5C3, 16'h5A3C, 16'hFFFF};

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    // R1 reset values, R11 unmapped reads
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], r);
      if (a < 8) chk("R1", r, (a == 1) ? 16'hFFFF : 16'h0000);
      else chk("R11", r, 16'h0000);
    end
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 pin_o", pin_o, 16'h0);
    chk("R1 oe", pin_oe, 16'h0);
    chk("R10 reset", gsel, 16'h0);

    foreach (pats[i]) begin
      wr(4'd1, pats[i]); chk("R2 oe", pin_oe, ~pats[i]);
      rd(4'd1, r);       chk("R2 rb", r, pats[i]);
      wr(4'd0, pats[i]); chk("R3 pin", pin_o, pats[i]);
      rd(4'd0, r);       chk("R3 rb", r, pats[i]);
      wr(4'd7, pats[i]); chk("R10 sel", gsel, pats[i]);
      rd(4'd7, r);       chk("R10 rb", r, pats[i]);
    end

    // R4 sampling with clock enable
    wr(4'd3, 16'hFFFF); rd(4'd3, r); chk("R4 ctrl", r, 16'h0020);
    foreach (pats[i]) begin
      set_pins(pats[i]); idle(4);
      rd(4'd2, r); chk("R4 in", r, pats[i]);
    end
    // R5 freeze: pins now 0xFFFF; arm falling edge on pin 3
    wr(4'd4, 16'h0007);
    rd(4'd5, r);
    wr(4'd3, 16'h0000);
    set_pins(16'h1234); idle(6);
    rd(4'd2, r); chk("R5 hold", r, 16'hFFFF);
    rd(4'd5, r); chk("R5 noevt", r & 16'h2, 16'h0);
    wr(4'd4, 16'h0000);
    wr(4'd3, 16'h0020); idle(5);
    rd(4'd2, r); chk("R4 resume", r, 16'h1234);

    // R7 disabled mode: edge on pin 0 with enable 0
    set_pins(16'h0000); idle(5); rd(4'd5, r);
    wr(4'd4, 16'h0020); set_pins(16'h0001); idle(5);
    rd(4'd5, r); chk("R7 off", r & 16'h2, 16'h0);

    // R6/R7/R8 sweep over pins and edges
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 2; e++) begin
        logic [15:0] lo, bp, bq;
        lo = (e == 1) ? 16'h0000 : 16'hFFFF;
        bp = 16'h1 << p;
        bq = 16'h1 << ((p + 1) % 16);
        wr(4'd4, 16'h0000);
        set_pins(lo); idle(5); rd(4'd5, r);
        wr(4'd4, 16'((e << 5) | (p << 1) | 1));
        set_pins(lo ^ bq); idle(5);
        rd(4'd5, r); chk("R7 other", r & 16'h2, 16'h0);
        set_pins(lo ^ bq ^ bp); idle(5);
        chk("R6 irq", {15'b0, irq}, 16'h1);
        rd(4'd5, r); chk("R6 set", r & 16'h2, 16'h2);
        rd(4'd5, r); chk("R8 clr", r & 16'h2, 16'h0);
        set_pins(lo ^ bq); idle(5);
        rd(4'd5, r); chk("R6 wrong edge", r & 16'h2, 16'h0);
      end
    end
    wr(4'd4, 16'h0000);

    // R8 keypad level, R9 masking
    @(negedge clk); kpd = 1;
    rd(4'd5, r); chk("R8 kpd", r, 16'h1);
    rd(4'd5, r); chk("R8 kpd stays", r, 16'h1);
    chk("R9 kpd irq", {15'b0, irq}, 16'h1);
    wr(4'd6, 16'h0001); chk("R9 kpd masked", {15'b0, irq}, 16'h0);
    wr(4'd6, 16'h0000); chk("R9 unmasked", {15'b0, irq}, 16'h1);
    @(negedge clk); kpd = 0;
    #1 chk("R9 kpd low", {15'b0, irq}, 16'h0);
    wr(4'd6, 16'h0002);
    set_pins(16'h0000); idle(5);
    wr(4'd4, 16'h0021); set_pins(16'h0001); idle(5);
    chk("R9 gpio masked", {15'b0, irq}, 16'h0);
    wr(4'd6, 16'h0000); chk("R9 gpio unmasked", {15'b0, irq}, 16'h1);
    rd(4'd5, r); chk("R8 read", r, 16'h2);
    chk("R8 irq cleared", {15'b0, irq}, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule